// File: doc/BRIEF.md
# Lane-Sliced Wide Trace Recorder

This block records a stream of wide trace words into a circular store and lets software dump that store through a narrow 32-bit register port. Each capture strobe writes one full-width word at the current write slot and moves the slot forward, wrapping at the store depth. Software never sees a whole word at once. Instead, every stored word is split into equal lanes, and software picks one lane at a time through a lane-select register.

For the selected lane, software can read the slot that capture will fill next and load that lane's own read pointer. It then pulls consecutive entries from a data register, and each read moves the lane's pointer forward by one. To dump the whole store, software runs once per lane: select the lane, load its pointer with the write slot so the oldest entry comes first, then read the data register depth times. The lanes from these passes are joined again in software.

Register reads complete one cycle after the request. The store is read into a full-width holding register, and the lane slice is picked from that register afterwards.

Top module: `lane_trace_buf`

## Requirements
- R1: After reset the write slot is 0, every lane's read pointer is 0 and the lane select is 0. The read-response valid is low and the read data is 0.
- R2: In every cycle with cap_valid high, cap_word is stored at the current write slot and the slot then advances by one, modulo DEPTH. When cap_valid is low, no entry is written and the slot holds.
- R3: A read of register address 1 returns the write slot, which is the entry the next capture will fill, zero-extended to 32 bits.
- R4: A write to register address 0 sets the lane select to the low log2(NUM_LANES) bits of reg_wdata. A read of address 0 returns the lane select.
- R5: A write to register address 2 loads the low log2(DEPTH) bits of reg_wdata into the read pointer of the selected lane only. A read of address 2 returns that lane's pointer, and the pointers of the other lanes are unchanged.
- R6: A read of register address 3 returns bits [LANE_W*s +: LANE_W] of the entry at lane s's read pointer, zero-extended, where s is the selected lane. It then advances only that lane's pointer by one, modulo DEPTH.
- R7: reg_rvalid is high in exactly the cycle after a cycle with reg_rd high, and reg_rdata carries the response in that cycle.
- R8: Writes to addresses 1 and 3 have no effect. The write slot, the read pointers and the stored data are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_valid | input | 1 | Capture strobe, one word per cycle |
| cap_word | input | LANE_W*NUM_LANES (256) | Trace word to store |
| reg_wr | input | 1 | Register write request |
| reg_rd | input | 1 | Register read request |
| reg_addr | input | 2 | Register select: 0 lane, 1 write slot, 2 read pointer, 3 data |
| reg_wdata | input | 32 | Register write data |
| reg_rvalid | output | 1 | Read response valid, one cycle after reg_rd |
| reg_rdata | output | 32 | Read response data |

## Verification
The hardest case to reach is a read pointer that wraps partway through a pass, in a store whose write slot has itself wrapped, so that the oldest entries sit above the newest. The bench captures more words than the store holds, which leaves the write slot in mid-store. It then loads each lane's pointer from that slot and reads a full depth of entries, so every pass crosses the top of the store. Pointer isolation between lanes is checked by loading two lanes with different values, advancing one of them, and reading both back.

// File: rtl/lane_trace_pkg.sv
package lane_trace_pkg;
   localparam int REG_W = 32;

   typedef enum logic [1:0] {
      RA_LANE = 2'd0,
      RA_WPTR = 2'd1,
      RA_RPTR = 2'd2,
      RA_DATA = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/trace_wr_ctl.sv
module trace_wr_ctl #(
   parameter int AW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cap_valid,
   output logic          mem_we,
   output logic [AW-1:0] wptr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wptr <= '0;
      else if (cap_valid)
         wptr <= wptr + 1'b1;
   end

   assign mem_we = cap_valid;
endmodule

// File: rtl/trace_mem.sv
module trace_mem #(
   parameter int AW = 9,
   parameter int DW = 256
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         store[waddr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (re)
         rdata <= store[raddr];
   end
endmodule

// File: rtl/trace_rptr_bank.sv
module trace_rptr_bank #(
   parameter int NUM_LANES = 8,
   parameter int AW        = 9,
   parameter int LSW       = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ld_en,
   input  logic           inc_en,
   input  logic [LSW-1:0] lane,
   input  logic [AW-1:0]  ld_val,
   output logic [AW-1:0]  cur
);
   logic [AW-1:0] ptr [NUM_LANES];

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      logic hit;
      assign hit = (lane == LSW'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ptr[g] <= '0;
         else if (ld_en && hit)
            ptr[g] <= ld_val;
         else if (inc_en && hit)
            ptr[g] <= ptr[g] + 1'b1;
      end
   end

   assign cur = ptr[lane];
endmodule

// File: rtl/lane_trace_buf.sv
module lane_trace_buf
   import lane_trace_pkg::*;
#(
   parameter int DEPTH     = 512,
   parameter int LANE_W    = 32,
   parameter int NUM_LANES = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cap_valid,
   input  logic [LANE_W*NUM_LANES-1:0]   cap_word,
   input  logic                          reg_wr,
   input  logic                          reg_rd,
   input  logic [1:0]                    reg_addr,
   input  logic [REG_W-1:0]              reg_wdata,
   output logic                          reg_rvalid,
   output logic [REG_W-1:0]              reg_rdata
);
   localparam int WORD_W = LANE_W * NUM_LANES;
   localparam int AW     = $clog2(DEPTH);
   localparam int LSW    = $clog2(NUM_LANES);

   if ((1 << AW) != DEPTH || DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if ((1 << LSW) != NUM_LANES || NUM_LANES < 2) begin : g_bad_lanes
      $error("NUM_LANES must be a power of two of at least 2");
   end
   if (LANE_W > REG_W || LANE_W < 1) begin : g_bad_lane_w
      $error("LANE_W must lie between 1 and the register width");
   end
   if (AW > REG_W) begin : g_bad_aw
      $error("pointer does not fit the register width");
   end

   reg_sel_e sel;
   assign sel = reg_sel_e'(reg_addr);

   logic [LSW-1:0] lane_sel;
   logic [AW-1:0]  wptr;
   logic [AW-1:0]  cur_rptr;
   logic           mem_we;
   logic [WORD_W-1:0] mem_q;
   logic           data_rd;
   logic           ptr_ld;

   assign data_rd = reg_rd && (sel == RA_DATA);
   assign ptr_ld  = reg_wr && (sel == RA_RPTR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lane_sel <= '0;
      else if (reg_wr && sel == RA_LANE)
         lane_sel <= reg_wdata[LSW-1:0];
   end

   trace_wr_ctl #(.AW(AW)) wr_ctl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_valid (cap_valid),
      .mem_we    (mem_we),
      .wptr      (wptr)
   );

   trace_mem #(.AW(AW), .DW(WORD_W)) mem_i (
      .clk   (clk),
      .we    (mem_we),
      .waddr (wptr),
      .wdata (cap_word),
      .re    (data_rd),
      .raddr (cur_rptr),
      .rdata (mem_q)
   );

   trace_rptr_bank #(.NUM_LANES(NUM_LANES), .AW(AW), .LSW(LSW)) rptr_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld_en  (ptr_ld),
      .inc_en (data_rd),
      .lane   (lane_sel),
      .ld_val (reg_wdata[AW-1:0]),
      .cur    (cur_rptr)
   );

   // response stage: non-data registers are captured directly,
   // the lane slice of the stored word is chosen after the read
   logic             resp_data;
   logic [LSW-1:0]   resp_lane;
   logic [REG_W-1:0] resp_misc;
   logic [REG_W-1:0] misc_d;

   always_comb begin
      case (sel)
         RA_LANE: misc_d = REG_W'(lane_sel);
         RA_WPTR: misc_d = REG_W'(wptr);
         RA_RPTR: misc_d = REG_W'(cur_rptr);
         default: misc_d = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_rvalid <= 1'b0;
         resp_data  <= 1'b0;
         resp_lane  <= '0;
         resp_misc  <= '0;
      end else begin
         reg_rvalid <= reg_rd;
         if (reg_rd) begin
            resp_data <= (sel == RA_DATA);
            resp_lane <= lane_sel;
            resp_misc <= misc_d;
         end
      end
   end

   logic [LANE_W-1:0] lane_words [NUM_LANES];
   for (genvar g = 0; g < NUM_LANES; g++) begin : g_slice
      assign lane_words[g] = mem_q[g*LANE_W +: LANE_W];
   end

   logic [REG_W-1:0] lane_out;
   if (LANE_W == REG_W) begin : g_full
      assign lane_out = lane_words[resp_lane];
   end else begin : g_ext
      assign lane_out = {{(REG_W-LANE_W){1'b0}}, lane_words[resp_lane]};
   end

   assign reg_rdata = resp_data ? lane_out : resp_misc;
endmodule

// File: rtl/lane_trace_chk.sv
module lane_trace_chk #(
   parameter int AW = 9
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cap_valid,
   input logic          reg_wr,
   input logic          reg_rd,
   input logic [1:0]    reg_addr,
   input logic          reg_rvalid,
   input logic [AW-1:0] wptr,
   input logic [AW-1:0] cur_rptr
);
   AST_WPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      cap_valid |=> wptr == AW'($past(wptr) + 1'b1)); // R2
   AST_WPTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_valid |=> $stable(wptr)); // R2
   AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |=> reg_rvalid); // R7
   AST_RVALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> !reg_rvalid); // R7
   AST_RPTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == 2'd3 && !reg_wr) |=> cur_rptr == AW'($past(cur_rptr) + 1'b1)); // R6
   AST_RO_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_rd && (reg_addr == 2'd1 || reg_addr == 2'd3)) |=> $stable(cur_rptr)); // R8
endmodule

bind lane_trace_buf lane_trace_chk #(.AW(AW)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .cap_valid  (cap_valid),
   .reg_wr     (reg_wr),
   .reg_rd     (reg_rd),
   .reg_addr   (reg_addr),
   .reg_rvalid (reg_rvalid),
   .wptr       (wptr),
   .cur_rptr   (cur_rptr)
);

// File: tb/lane_trace_buf_tb.sv
module lane_trace_buf_tb_top;
   localparam int DEPTH  = 16;
   localparam int LANE_W = 8;
   localparam int NL     = 8;
   localparam int WW     = LANE_W * NL;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cap_valid = 1'b0;
   logic [WW-1:0] cap_word = '0;
   logic          reg_wr = 1'b0;
   logic          reg_rd = 1'b0;
   logic [1:0]    reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic          reg_rvalid;
   logic [31:0]   reg_rdata;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int exp_k [DEPTH];
   int wslot = 0;
   logic [31:0] got;

   always #5 clk = ~clk;

   lane_trace_buf #(.DEPTH(DEPTH), .LANE_W(LANE_W), .NUM_LANES(NL)) dut_i (
      .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_word(cap_word),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata));

   function automatic logic [LANE_W-1:0] lane_val(int k, int l);
      return LANE_W'(k * 29 + l * 7 + 3);
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic capture(int k);
      @(negedge clk);
      cap_valid = 1'b1;
      for (int l = 0; l < NL; l++) cap_word[l*LANE_W +: LANE_W] = lane_val(k, l);
      @(negedge clk);
      cap_valid = 1'b0;
      exp_k[wslot] = k;
      wslot = (wslot + 1) % DEPTH;
   endtask

   task automatic wr(logic [1:0] a, logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected below 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      check("R1 rvalid", 32'(reg_rvalid), 0);
      check("R1 rdata", reg_rdata, 0);
      rd(2'd1, got); check("R1 wptr", got, 0);
      rd(2'd0, got); check("R1 lane", got, 0);
      for (int l = 0; l < NL; l++) begin
         wr(2'd0, 32'(l));
         rd(2'd2, got); check("R1 rptr", got, 0);
      end

      // R2 / R3: captures with idle gaps, then wrap of the write slot
      for (int k = 0; k < 10; k++) capture(k);
      rd(2'd1, got); check("R3 wptr", got, 10);
      for (int k = 10; k < 22; k++) capture(k);
      rd(2'd1, got); check("R2 wptr wrap", got, 32'(22 % DEPTH));

      // R6: full dump, lane by lane, oldest entry first
      for (int l = 0; l < NL; l++) begin
         wr(2'd0, 32'(l));
         rd(2'd0, got); check("R4 lane readback", got, 32'(l));
         wr(2'd2, 32'(wslot));
         for (int i = 0; i < DEPTH; i++) begin
            rd(2'd3, got);
            check("R6 R2 dump data", got,
                  32'(lane_val(exp_k[(wslot + i) % DEPTH], l)));
         end
         rd(2'd2, got); check("R6 rptr wrap", got, 32'(wslot));
      end

      // R5: per-lane pointer isolation
      wr(2'd0, 2); wr(2'd2, 5);
      wr(2'd0, 6); wr(2'd2, 11);
      rd(2'd3, got); check("R6 lane6 data", got, 32'(lane_val(exp_k[11], 6)));
      rd(2'd2, got); check("R6 lane6 advance", got, 12);
      wr(2'd0, 2);
      rd(2'd2, got); check("R5 lane2 kept", got, 5);
      rd(2'd3, got); check("R6 lane2 data", got, 32'(lane_val(exp_k[5], 2)));
      rd(2'd2, got); check("R5 load", got, 6);

      // R8: writes to read-only addresses
      wr(2'd1, 32'h3);
      wr(2'd3, 32'hFF);
      rd(2'd1, got); check("R8 wptr", got, 32'(wslot));
      rd(2'd2, got); check("R8 rptr", got, 6);
      rd(2'd3, got); check("R8 data", got, 32'(lane_val(exp_k[6], 2)));

      // R4: only low bits of the lane select are kept
      wr(2'd0, 32'hFFFF_FFFB);
      rd(2'd0, got); check("R4 lane truncate", got, 3);

      // R7: response timing
      @(negedge clk);
      check("R7 idle", 32'(reg_rvalid), 0);
      reg_rd = 1'b1; reg_addr = 2'd1;
      @(negedge clk);
      reg_rd = 1'b0;
      check("R7 valid", 32'(reg_rvalid), 1);
      check("R7 data", reg_rdata, 32'(wslot));
      @(negedge clk);
      check("R7 drop", 32'(reg_rvalid), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule